// File: doc/BRIEF.md
# Misaligned Access Fault Checker

This block judges every data memory reference that the load/store path presents and decides whether it must raise an alignment fault. Each reference arrives with its effective address and a code for the kind of data being moved. It also carries the operand-size mode, the current privilege level, the alignment-check enable flag and a qualifier. The qualifier marks implicit supervisor references such as descriptor-table or task-state reads. The required boundary is taken from a per-kind table, not from the transfer width alone. The FPU save-area kinds take their boundary from the operand-size mode.

A fault is possible only when checking is enabled, the privilege level is 3 and the reference is not an implicit supervisor reference. The verdict is registered. A fault shows as a one-cycle strobe together with vector number 17 and an all-zero error code. The fault outputs follow one clock after the cycle in which the request was valid.

The request side is a stream input with a valid qualifier only. Every request is judged in the cycle it appears, so the block never applies back-pressure and needs no ready signal. The fault outputs are plain status pins with no handshake. A downstream exception unit must take the strobe in the cycle it is high.

Top module: `align_fault_check`

## Requirements
- R1: While `ac_en` is 0, `fault_o` stays 0 for every request.
- R2: While `req_cpl` is 0, 1 or 2, `fault_o` stays 0 whatever `ac_en` holds.
- R3: A request with `sys_ref` at 1 never causes a fault, even at privilege level 3.
- R4: Kind code 0 (byte) never faults. The unassigned kind codes 14 and 15 never fault either.
- R5: Kind codes 1 (word), 6 (selector) and 9 (16:16 pointer) need 2-byte alignment. When checking applies, they fault exactly when address bit 0 is 1.
- R6: Some kind codes need 4-byte alignment: 2 (dword), 3 (single real), 7 (16:32 pointer), 8 (flat 32-bit pointer), 10 (table pseudo-descriptor) and 13 (bit string). When checking applies, they fault exactly when address bits 1:0 are not 00.
- R7: Kind codes 4 (double real) and 5 (extended real) need 8-byte alignment. When checking applies, they fault exactly when address bits 2:0 are not 000.
- R8: Kind codes 11 (FPU environment area) and 12 (FPU full-state area) need 4-byte alignment when `req_op32` is 1 and 2-byte alignment when it is 0.
- R9: When `fault_o` is 1, `fault_vec` is 17 and `fault_err` is 0. When `fault_o` is 0, both are 0.
- R10: The verdict for a request presented in the cycle ending at clock edge N appears on the outputs after edge N and holds for exactly one cycle. A cycle with `req_valid` at 0 produces no fault in the following cycle.
- R11: A synchronous reset (`rst` at 1 on an edge) clears all fault outputs after that edge, including any verdict pending from the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A reference is presented this cycle |
| req_addr | input | 32 | Effective address of the reference |
| req_kind | input | 4 | Data kind code (see R4 to R8) |
| req_op32 | input | 1 | 1 for 32-bit operand size, 0 for 16-bit |
| req_cpl | input | 2 | Current privilege level |
| ac_en | input | 1 | Alignment-check enable flag |
| sys_ref | input | 1 | Implicit supervisor (system table) reference |
| fault_o | output | 1 | Alignment fault strobe |
| fault_vec | output | 8 | Fault vector number |
| fault_err | output | 32 | Fault error code |

## Verification
A synchronous reset and a faulting request can land on the same clock edge. The reset must win, so the verdict is dropped. The bench provokes this by asserting `rst` in the same cycle as a misaligned level-3 double-real request. The reference model then expects all outputs at zero after that edge. Back-to-back faulting requests are also applied with no gap between them. The model expects a fault in each following cycle, so a strobe that stretches or merges across requests shows up as a miscompare.

// File: rtl/align_pkg.sv
package align_pkg;

  // Data kind codes carried on req_kind
  typedef enum logic [3:0] {
    KIND_BYTE      = 4'd0,
    KIND_WORD      = 4'd1,
    KIND_DWORD     = 4'd2,
    KIND_REAL32    = 4'd3,
    KIND_REAL64    = 4'd4,
    KIND_REAL80    = 4'd5,
    KIND_SELECTOR  = 4'd6,
    KIND_PTR48     = 4'd7,
    KIND_PTRFLAT   = 4'd8,
    KIND_PTR32     = 4'd9,
    KIND_PSEUDO    = 4'd10,
    KIND_FPU_ENV   = 4'd11,
    KIND_FPU_STATE = 4'd12,
    KIND_BITSTR    = 4'd13
  } access_kind_e;

  localparam int unsigned KIND_W = 4;

  // Boundary exponent: required alignment is 2**exp bytes
  typedef logic [1:0] align_exp_t;

  localparam align_exp_t EXP_1 = 2'd0;
  localparam align_exp_t EXP_2 = 2'd1;
  localparam align_exp_t EXP_4 = 2'd2;
  localparam align_exp_t EXP_8 = 2'd3;

endpackage

// File: rtl/align_kind_decode.sv
module align_kind_decode
  import align_pkg::*;
#(
  parameter int unsigned MASK_W = 3
) (
  input  logic [KIND_W-1:0] kind,
  input  logic              op32,
  output logic [MASK_W-1:0] mask
);

  align_exp_t exp_sel;

  always_comb begin
    unique case (access_kind_e'(kind))
      KIND_WORD, KIND_SELECTOR, KIND_PTR32:
        exp_sel = EXP_2;
      KIND_DWORD, KIND_REAL32, KIND_PTR48, KIND_PTRFLAT,
      KIND_PSEUDO, KIND_BITSTR:
        exp_sel = EXP_4;
      KIND_REAL64, KIND_REAL80:
        exp_sel = EXP_8;
      KIND_FPU_ENV, KIND_FPU_STATE:
        exp_sel = op32 ? EXP_4 : EXP_2;
      default:
        exp_sel = EXP_1;
    endcase
  end

  // mask = boundary - 1, one bit per low address bit
  for (genvar b = 0; b < MASK_W; b++) begin : g_mask
    assign mask[b] = (int'(exp_sel) > b);
  end

endmodule

// File: rtl/align_addr_test.sv
module align_addr_test #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MASK_W-1:0] mask,
  output logic              misaligned
);

  localparam int unsigned PAD_W = ADDR_W - MASK_W;

  logic [ADDR_W-1:0] mask_full;
  logic [ADDR_W-1:0] hit;

  assign mask_full = {{PAD_W{1'b0}}, mask};

  for (genvar i = 0; i < ADDR_W; i++) begin : g_hit
    assign hit[i] = addr[i] & mask_full[i];
  end

  assign misaligned = |hit;

endmodule

// File: rtl/align_fault_reg.sv
module align_fault_reg #(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned ERR_W     = 32,
  parameter int unsigned FAULT_VEC = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raise,
  output logic             fault_o,
  output logic [VEC_W-1:0] fault_vec,
  output logic [ERR_W-1:0] fault_err
);

  localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(FAULT_VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o   <= 1'b0;
      fault_vec <= '0;
      fault_err <= '0;
    end else begin
      fault_o   <= raise;
      fault_vec <= raise ? VEC_VAL : '0;
      fault_err <= '0;
    end
  end

  // R9
  vec_match_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (fault_vec == VEC_VAL && fault_err == '0));

  // R9
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_o |-> (fault_vec == '0 && fault_err == '0));

endmodule

// File: rtl/align_fault_check.sv
module align_fault_check
  import align_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CPL_W     = 2,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned ERR_W     = 32,
  parameter int unsigned FAULT_CPL = 3,
  parameter int unsigned FAULT_VEC = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_kind,
  input  logic              req_op32,
  input  logic [CPL_W-1:0]  req_cpl,
  input  logic              ac_en,
  input  logic              sys_ref,
  output logic              fault_o,
  output logic [VEC_W-1:0]  fault_vec,
  output logic [ERR_W-1:0]  fault_err
);

  localparam int unsigned MASK_W = 3;
  localparam logic [CPL_W-1:0] USER_CPL = CPL_W'(FAULT_CPL);

  logic [MASK_W-1:0] need_mask;
  logic              misaligned;
  logic              armed;
  logic              raise;

  align_kind_decode #(.MASK_W(MASK_W)) u_decode (
    .kind (req_kind),
    .op32 (req_op32),
    .mask (need_mask)
  );

  align_addr_test #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_test (
    .addr       (req_addr),
    .mask       (need_mask),
    .misaligned (misaligned)
  );

  // checking applies only to enabled, user-level, non-system references
  assign armed = req_valid & ac_en & (req_cpl == USER_CPL) & ~sys_ref;
  assign raise = armed & misaligned;

  align_fault_reg #(
    .VEC_W(VEC_W), .ERR_W(ERR_W), .FAULT_VEC(FAULT_VEC)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .raise     (raise),
    .fault_o   (fault_o),
    .fault_vec (fault_vec),
    .fault_err (fault_err)
  );

  // R1
  no_fault_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> $past(ac_en));

  // R2
  user_level_only_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> ($past(req_cpl) == USER_CPL));

  // R3
  system_ref_exempt_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !$past(sys_ref));

  // R4
  byte_never_faults_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid) && $past(req_kind) == 4'd0) |-> !fault_o);

  // R10
  needs_request_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> !fault_o);

  // R5
  odd_addr_needed_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> ($past(req_addr[2:0]) != 3'b000));

endmodule

// File: tb/align_fault_check_test.sv
module align_fault_check_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [3:0]  req_kind;
  logic        req_op32;
  logic [1:0]  req_cpl;
  logic        ac_en;
  logic        sys_ref;
  logic        fault_o;
  logic [7:0]  fault_vec;
  logic [31:0] fault_err;

  int vectors  = 0;
  int failures = 0;

  bit    pend_fault;
  string pend_tag;

  always #2 clk = ~clk;

  align_fault_check uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_op32(req_op32), .req_cpl(req_cpl),
    .ac_en(ac_en), .sys_ref(sys_ref), .fault_o(fault_o),
    .fault_vec(fault_vec), .fault_err(fault_err)
  );

  function automatic int boundary(input int kind, input bit op32);
    if (kind == 1 || kind == 6 || kind == 9) return 2;
    if (kind == 2 || kind == 3 || kind == 7 || kind == 8 || kind == 10 || kind == 13) return 4;
    if (kind == 4 || kind == 5) return 8;
    if (kind == 11 || kind == 12) return op32 ? 4 : 2;
    return 1;
  endfunction

  function automatic bit model(input bit r, input bit v, input logic [31:0] a,
                               input int k, input bit o, input int c,
                               input bit en, input bit s);
    if (r || !v || !en || c != 3 || s) return 1'b0;
    return (a % boundary(k, o)) != 0;
  endfunction

  function automatic string tag_for(input int k, input bit o, input int c,
                                    input bit en, input bit s);
    if (!en) return "R1";
    if (c != 3) return "R2";
    if (s) return "R3";
    case (boundary(k, o))
      1: return "R4";
      2: return (k == 11 || k == 12) ? "R8" : "R5";
      4: return (k == 11 || k == 12) ? "R8" : "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    bit   e = pend_fault;
    logic [7:0] ev = e ? 8'd17 : 8'd0;
    vectors++;
    if (fault_o !== e || fault_vec !== ev || fault_err !== 32'd0) begin
      failures++;
      $display("FAIL %s (R9/R10): fault=%0d vec=%0d err=%0h expected fault=%0d vec=%0d err=0",
               pend_tag, fault_o, fault_vec, fault_err, e, ev);
    end
  endtask

  // one cycle: check previous verdict, then drive a new request
  task automatic step(input bit r, input bit v, input logic [31:0] a, input int k,
                      input bit o, input int c, input bit en, input bit s,
                      input string tg);
    @(negedge clk);
    compare();
    rst = r; req_valid = v; req_addr = a; req_kind = 4'(k);
    req_op32 = o; req_cpl = 2'(c); ac_en = en; sys_ref = s;
    pend_fault = model(r, v, a, k, o, c, en, s);
    pend_tag   = tg;
  endtask

  task automatic user(input logic [31:0] a, input int k, input bit o, input string tg);
    step(1'b0, 1'b1, a, k, o, 3, 1'b1, 1'b0, tg);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

  initial begin : stim
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_kind = '0;
    req_op32 = 1'b1; req_cpl = 2'd0; ac_en = 1'b0; sys_ref = 1'b0;
    pend_fault = 1'b0; pend_tag = "R11";
    repeat (3) @(posedge clk);
    // reset state check (R11)
    step(1'b1, 1'b0, 32'h0, 0, 1, 3, 1, 0, "R11");
    step(1'b0, 1'b0, 32'h0, 0, 1, 3, 1, 0, "R11");

    // R1: enable off
    step(1'b0, 1'b1, 32'h1003, 4, 1, 3, 1'b0, 1'b0, "R1");
    // R2: levels 0..2
    for (int c = 0; c < 3; c++) step(1'b0, 1'b1, 32'h7, 2, 1, c, 1'b1, 1'b0, "R2");
    // R3: system reference at level 3
    step(1'b0, 1'b1, 32'h5, 5, 1, 3, 1'b1, 1'b1, "R3");
    // R4: byte and unassigned codes
    user(32'h7, 0, 1, "R4");
    user(32'h3, 14, 1, "R4");
    user(32'h1, 15, 0, "R4");
    // R5
    user(32'h11, 1, 1, "R5");
    user(32'h12, 6, 1, "R5");
    user(32'h3, 9, 0, "R5");
    // R6
    user(32'h2, 2, 1, "R6");
    user(32'h4, 3, 1, "R6");
    user(32'h9, 10, 1, "R6");
    user(32'h100, 13, 1, "R6");
    // R7
    user(32'h4, 4, 1, "R7");
    user(32'h8, 5, 1, "R7");
    user(32'h7, 5, 0, "R7");
    // R8: save areas by operand size
    user(32'h2, 11, 1, "R8");
    user(32'h2, 11, 0, "R8");
    user(32'h1, 12, 0, "R8");
    user(32'h4, 12, 1, "R8");
    // R10: back-to-back faults, then a gap
    user(32'h1, 1, 1, "R10");
    user(32'h1, 1, 1, "R10");
    step(1'b0, 1'b0, 32'h1, 1, 1, 3, 1, 0, "R10");
    user(32'h6, 2, 1, "R10");
    // R11: reset in the same cycle as a faulting request
    step(1'b1, 1'b1, 32'h3, 4, 1, 3, 1'b1, 1'b0, "R11");
    step(1'b0, 1'b0, 32'h0, 0, 1, 3, 1, 0, "R11");

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a  = $urandom;
      int          k  = int'($urandom_range(15, 0));
      bit          o  = 1'($urandom);
      int          c  = ($urandom_range(3, 0) == 0) ? int'($urandom_range(2, 0)) : 3;
      bit          en = ($urandom_range(7, 0) != 0);
      bit          s  = ($urandom_range(7, 0) == 0);
      bit          v  = ($urandom_range(5, 0) != 0);
      step(1'b0, v, a, k, o, c, en, s, tag_for(k, o, c, en, s));
    end
    step(1'b0, 1'b0, 32'h0, 0, 1, 0, 0, 0, "R10");
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

endmodule